// File: doc/BRIEF.md
# Host Controller Interrupt Status Register

This block collects the events raised inside a full/low-speed USB host controller and holds them in a 32-bit status word that driver software reads and acknowledges. The event sources are the frame timer, the root hub, the done-queue writeback engine, the list scheduler, the system error detector and the ownership-change logic. Several bits are not driven by a raw strobe but by a derived condition:

- a flip of the frame counter's top bit, reported once the in-memory frame number copy has been refreshed;
- a rising edge on remote resume that software did not command;
- a done-head writeback flag that stalls further writebacks until software acknowledges it.

A small register port gives access to the status word, an enable register and a wrapping count of schedule overruns. Enabled status bits are combined into an interrupt line. The ownership-change bit is routed on its own to a system management interrupt line. When the parameter `HAS_SMI` is 0, that bit is held at zero.

Top module: `hc_irq_status`

## Requirements
- R1: After reset the status word, the enable register and the overrun count read 0, `irq` and `smi` are 0 and `wb_permit` is 1.
- R2: Register addresses are: 0 for status, 1 for enable, 2 for the overrun count. Status bit positions are: schedule overrun 0, writeback done 1, start of frame 2, resume detected 3, unrecoverable error 4, frame-number overflow 5, root hub change 6, ownership change 30. The enable register uses the same positions plus a master enable at bit 31. Every other bit of both registers reads 0.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the bit at 1.
- R4: Bit 5 sets on a `frame_copy_done` pulse only when `frame_msb` has changed, in either direction, since the previous pulse or in the pulse cycle itself. A pulse with no change does not set it.
- R5: An `ev_sof` pulse sets bit 2.
- R6: Bit 3 sets on a 0-to-1 transition of `resume_line`, and only when `sw_resume` is 0 in that cycle. A level held high does not set it again.
- R7: An `ev_donehead_written` pulse sets bit 1. `wb_permit` is 0 while bit 1 is 1 and returns to 1 once it is cleared.
- R8: An `ev_sched_overrun` pulse sets bit 0 and adds one to the overrun count. The count is `OVR_W` bits wide (default 2) and wraps to 0.
- R9: An `ev_own_req` pulse sets bit 30. `smi` is 1 when bit 30, its enable and the master enable are all 1. Bit 30 never drives `irq`. With `HAS_SMI` = 0, bit 30 stays 0 and `smi` stays 0.
- R10: `irq` is the master enable ANDed with the OR of the enabled status bits 0 to 6.
- R11: An `ev_sys_error` pulse sets bit 4, and an `ev_rh_change` pulse sets bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_sched_overrun | input | 1 | Frame schedule overran |
| ev_donehead_written | input | 1 | Done-head pointer stored to memory |
| ev_sof | input | 1 | Start of frame, issued with the SOF token |
| ev_sys_error | input | 1 | Non-USB system error |
| ev_rh_change | input | 1 | Root hub or port status changed |
| ev_own_req | input | 1 | Software ownership change request |
| frame_msb | input | 1 | Top bit of the frame counter |
| frame_copy_done | input | 1 | In-memory frame number refreshed |
| resume_line | input | 1 | Remote resume signaling present |
| sw_resume | input | 1 | Software has commanded resume |
| irq | output | 1 | Gated interrupt line |
| smi | output | 1 | System management interrupt line |
| wb_permit | output | 1 | Done-head writeback allowed |
| status_word | output | 32 | Current status word |

## Verification
The bench times a clear to land in the same cycle as a set. A design that gave the clear priority would lose the event and read 0.

It moves the frame counter's top bit before the copy-done pulse and checks that nothing appears early. It then pulses copy-done with no flip in between, and a design that sampled the level instead of the change would set the bit falsely.

Resume is raised while software owns the resume state, then held high across a clear. An edge detector that ignored `sw_resume` would set the bit in the first case, and a level detector would set it again in the second.

The overrun count is driven past its top value to expose a counter that saturates. Ownership change is checked on both parameter variants and with only that bit enabled, which catches a design that leaks bit 30 into `irq`.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
   localparam int unsigned REG_W = 32;

   localparam int unsigned B_SO     = 0;
   localparam int unsigned B_WDH    = 1;
   localparam int unsigned B_SF     = 2;
   localparam int unsigned B_RD     = 3;
   localparam int unsigned B_UE     = 4;
   localparam int unsigned B_FNO    = 5;
   localparam int unsigned B_RHSC   = 6;
   localparam int unsigned B_OC     = 30;
   localparam int unsigned B_MASTER = 31;

   localparam logic [1:0] A_STATUS = 2'd0;
   localparam logic [1:0] A_ENABLE = 2'd1;
   localparam logic [1:0] A_OVRCNT = 2'd2;

   localparam logic [REG_W-1:0] LOW_EVT_MASK = 32'h0000_007F;

   typedef struct packed {
      logic oc;
      logic rhsc;
      logic fno;
      logic ue;
      logic rd;
      logic sf;
      logic wdh;
      logic so;
   } hc_evt_t;

   function automatic logic [REG_W-1:0] evt_to_word(input hc_evt_t e);
      logic [REG_W-1:0] w;
      w         = '0;
      w[B_SO]   = e.so;
      w[B_WDH]  = e.wdh;
      w[B_SF]   = e.sf;
      w[B_RD]   = e.rd;
      w[B_UE]   = e.ue;
      w[B_FNO]  = e.fno;
      w[B_RHSC] = e.rhsc;
      w[B_OC]   = e.oc;
      return w;
   endfunction
endpackage

// File: rtl/hc_irq_event_detect.sv
module hc_irq_event_detect
   import hc_irq_pkg::*;
#(
   parameter bit HAS_SMI = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    so_pulse,
   input  logic    wdh_pulse,
   input  logic    sof_pulse,
   input  logic    syserr_pulse,
   input  logic    rh_change_pulse,
   input  logic    own_req_pulse,
   input  logic    frame_msb,
   input  logic    frame_copy_done,
   input  logic    resume_line,
   input  logic    sw_resume,
   output hc_evt_t evt
);
   logic msb_q;
   logic msb_pend_q;
   logic resume_q;
   logic msb_flip;
   logic oc_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msb_q      <= 1'b0;
         msb_pend_q <= 1'b0;
         resume_q   <= 1'b0;
      end else begin
         msb_q      <= frame_msb;
         msb_pend_q <= (msb_pend_q | msb_flip) & ~frame_copy_done;
         resume_q   <= resume_line;
      end
   end

   assign msb_flip = frame_msb ^ msb_q;

   generate
      if (HAS_SMI) begin : g_oc_live
         assign oc_evt = own_req_pulse;
      end else begin : g_oc_tied
         assign oc_evt = 1'b0 & own_req_pulse;
      end
   endgenerate

   always_comb begin
      evt      = '0;
      evt.so   = so_pulse;
      evt.wdh  = wdh_pulse;
      evt.sf   = sof_pulse;
      evt.ue   = syserr_pulse;
      evt.rhsc = rh_change_pulse;
      evt.fno  = frame_copy_done & (msb_pend_q | msb_flip);
      evt.rd   = resume_line & ~resume_q & ~sw_resume;
      evt.oc   = oc_evt;
   end
endmodule

// File: rtl/hc_irq_status_bits.sv
module hc_irq_status_bits
   import hc_irq_pkg::*;
#(
   parameter logic [REG_W-1:0] IMPL_MASK = 32'h4000_007F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_w,
   input  logic [REG_W-1:0] clr_w,
   output logic [REG_W-1:0] status_q
);
   logic [REG_W-1:0] status_d;

   assign status_d = ((status_q & ~clr_w) | set_w) & IMPL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end
endmodule

// File: rtl/hc_irq_enable_gate.sv
module hc_irq_enable_gate
   import hc_irq_pkg::*;
#(
   parameter logic [REG_W-1:0] IMPL_MASK = 32'h4000_007F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] status,
   output logic [REG_W-1:0] en_q,
   output logic             irq,
   output logic             smi
);
   localparam logic [REG_W-1:0] EN_MASK  = IMPL_MASK | (32'h1 << B_MASTER);
   localparam logic [REG_W-1:0] IRQ_MASK = IMPL_MASK & LOW_EVT_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= wdata & EN_MASK;
   end

   assign irq = en_q[B_MASTER] & (|(status & en_q & IRQ_MASK));
   assign smi = en_q[B_MASTER] & en_q[B_OC] & status[B_OC];
endmodule

// File: rtl/hc_irq_ovr_counter.sv
module hc_irq_ovr_counter #(
   parameter int unsigned OVR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [OVR_W-1:0] cnt_q
);
   localparam logic [OVR_W-1:0] ONE = OVR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + ONE;
   end
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
   import hc_irq_pkg::*;
#(
   parameter bit          HAS_SMI = 1'b1,
   parameter int unsigned OVR_W   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        ev_sched_overrun,
   input  logic        ev_donehead_written,
   input  logic        ev_sof,
   input  logic        ev_sys_error,
   input  logic        ev_rh_change,
   input  logic        ev_own_req,
   input  logic        frame_msb,
   input  logic        frame_copy_done,
   input  logic        resume_line,
   input  logic        sw_resume,
   output logic        irq,
   output logic        smi,
   output logic        wb_permit,
   output logic [31:0] status_word
);
   localparam logic [REG_W-1:0] OC_BIT    = HAS_SMI ? (32'h1 << B_OC) : 32'h0;
   localparam logic [REG_W-1:0] IMPL_MASK = LOW_EVT_MASK | OC_BIT;
   localparam int unsigned      PAD_W     = REG_W - OVR_W;

   generate
      if (OVR_W < 1 || OVR_W > 16) begin : g_bad_ovr_w
         $error("hc_irq_status: OVR_W must lie in 1..16");
      end
   endgenerate

   hc_evt_t          evt;
   logic [REG_W-1:0] set_w;
   logic [REG_W-1:0] clr_w;
   logic [REG_W-1:0] status_q;
   logic [REG_W-1:0] en_q;
   logic [OVR_W-1:0] ovr_cnt;
   logic             wr_status;
   logic             wr_enable;

   assign wr_status = reg_wr & (reg_addr == A_STATUS);
   assign wr_enable = reg_wr & (reg_addr == A_ENABLE);

   hc_irq_event_detect #(.HAS_SMI(HAS_SMI)) u_detect (
      .clk             (clk),
      .rst_n           (rst_n),
      .so_pulse        (ev_sched_overrun),
      .wdh_pulse       (ev_donehead_written),
      .sof_pulse       (ev_sof),
      .syserr_pulse    (ev_sys_error),
      .rh_change_pulse (ev_rh_change),
      .own_req_pulse   (ev_own_req),
      .frame_msb       (frame_msb),
      .frame_copy_done (frame_copy_done),
      .resume_line     (resume_line),
      .sw_resume       (sw_resume),
      .evt             (evt)
   );

   assign set_w = evt_to_word(evt);
   assign clr_w = wr_status ? reg_wdata : '0;

   hc_irq_status_bits #(.IMPL_MASK(IMPL_MASK)) u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_w    (set_w),
      .clr_w    (clr_w),
      .status_q (status_q)
   );

   hc_irq_enable_gate #(.IMPL_MASK(IMPL_MASK)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_enable),
      .wdata  (reg_wdata),
      .status (status_q),
      .en_q   (en_q),
      .irq    (irq),
      .smi    (smi)
   );

   hc_irq_ovr_counter #(.OVR_W(OVR_W)) u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt.so),
      .cnt_q (ovr_cnt)
   );

   assign wb_permit   = ~status_q[B_WDH];
   assign status_word = status_q;

   always_comb begin
      case (reg_addr)
         A_STATUS: reg_rdata = status_q;
         A_ENABLE: reg_rdata = en_q;
         A_OVRCNT: reg_rdata = {{PAD_W{1'b0}}, ovr_cnt};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hc_irq_status_chk.sv
module hc_irq_status_chk #(
   parameter int unsigned OVR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_sched_overrun,
   input logic             ev_donehead_written,
   input logic             frame_copy_done,
   input logic             resume_line,
   input logic             sw_resume,
   input logic             irq,
   input logic             smi,
   input logic             wb_permit,
   input logic [31:0]      status_word,
   input logic [31:0]      en,
   input logic [OVR_W-1:0] cnt
);
   a_r7_permit_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_donehead_written) |-> !wb_permit);

   a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_sched_overrun) |-> status_word[0]);

   a_r4_fno_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[5]) |-> $past(frame_copy_done));

   a_r6_resume_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[3]) |-> $past(resume_line && !sw_resume));

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_sched_overrun) |-> cnt == OVR_W'($past(cnt) + 1'b1));

   a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ev_sched_overrun) |-> $stable(cnt));

   a_r9_smi_source: assert property (@(posedge clk) disable iff (!rst_n)
      smi |-> status_word[30]);

   a_r10_irq_master: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> en[31]);
endmodule

bind hc_irq_status hc_irq_status_chk #(.OVR_W(OVR_W)) u_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .ev_sched_overrun    (ev_sched_overrun),
   .ev_donehead_written (ev_donehead_written),
   .frame_copy_done     (frame_copy_done),
   .resume_line         (resume_line),
   .sw_resume           (sw_resume),
   .irq                 (irq),
   .smi                 (smi),
   .wb_permit           (wb_permit),
   .status_word         (status_word),
   .en                  (en_q),
   .cnt                 (ovr_cnt)
);

// File: tb/tb_hc_irq_status.sv
`timescale 1ns/100ps
module tb_hc_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata, rdata_ns;
   logic        ev_so = 0, ev_wdh = 0, ev_sf = 0, ev_ue = 0, ev_rh = 0, ev_oc = 0;
   logic        frame_msb = 0, frame_copy_done = 0, resume_line = 0, sw_resume = 0;
   logic        irq, smi, wb_permit, irq_ns, smi_ns, permit_ns;
   logic [31:0] status_word, status_ns;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   hc_irq_status dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata),
      .ev_sched_overrun(ev_so), .ev_donehead_written(ev_wdh), .ev_sof(ev_sf),
      .ev_sys_error(ev_ue), .ev_rh_change(ev_rh), .ev_own_req(ev_oc),
      .frame_msb(frame_msb), .frame_copy_done(frame_copy_done),
      .resume_line(resume_line), .sw_resume(sw_resume),
      .irq(irq), .smi(smi), .wb_permit(wb_permit), .status_word(status_word)
   );

   hc_irq_status #(.HAS_SMI(1'b0)) dut_nosmi (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_ns),
      .ev_sched_overrun(ev_so), .ev_donehead_written(ev_wdh), .ev_sof(ev_sf),
      .ev_sys_error(ev_ue), .ev_rh_change(ev_rh), .ev_own_req(ev_oc),
      .frame_msb(frame_msb), .frame_copy_done(frame_copy_done),
      .resume_line(resume_line), .sw_resume(sw_resume),
      .irq(irq_ns), .smi(smi_ns), .wb_permit(permit_ns), .status_word(status_ns)
   );

   // vector: {strobes oc,rhsc,ue,sf,wdh,so ; clear mask ; expected status}
   localparam int NVEC = 8;
   localparam logic [69:0] VEC [NVEC] = '{
      {6'b000001, 32'h0000_0000, 32'h0000_0001},
      {6'b001100, 32'h0000_0000, 32'h0000_0015},
      {6'b010000, 32'h0000_0001, 32'h0000_0054},
      {6'b100000, 32'h0000_0000, 32'h4000_0054},
      {6'b000010, 32'h4000_0004, 32'h0000_0052},
      {6'b000001, 32'h0000_0001, 32'h0000_0053},
      {6'b000000, 32'hFFFF_FFFF, 32'h0000_0000},
      {6'b000000, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = rdata;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); check("R1 status", v, 32'h0);
      rd(2'd1, v); check("R1 enable", v, 32'h0);
      rd(2'd2, v); check("R1 count", v, 32'h0);
      check("R1 irq/smi/permit", {29'd0, irq, smi, wb_permit}, 32'h1);

      // R3 R5 R7 R8 R9 R11 vector walk
      for (int i = 0; i < NVEC; i++) begin
         {ev_oc, ev_rh, ev_ue, ev_sf, ev_wdh, ev_so} = VEC[i][69:64];
         if (VEC[i][63:32] != 32'h0) begin
            reg_addr = 2'd0; reg_wdata = VEC[i][63:32]; reg_wr = 1'b1;
         end
         step();
         {ev_oc, ev_rh, ev_ue, ev_sf, ev_wdh, ev_so} = '0;
         reg_wr = 1'b0; reg_wdata = '0;
         rd(2'd0, v);
         check($sformatf("R3/R11 vector %0d", i), v, VEC[i][31:0]);
         check($sformatf("R9 nosmi vector %0d", i), rdata_ns, VEC[i][31:0] & 32'hBFFF_FFFF);
      end

      // R8 count and wrap
      rd(2'd2, v); check("R8 count after two overruns", v, 32'd2);
      ev_so = 1; step(); step(); ev_so = 0;
      rd(2'd2, v); check("R8 count wraps", v, 32'd0);
      wr(2'd0, 32'hFFFF_FFFF);

      // R2 layout of enable and reserved status bits
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R2 enable readback", v, 32'hC000_007F);
      wr(2'd1, 32'h0);
      rd(2'd0, v); check("R2 status reserved", v, 32'h0);

      // R7 writeback hold-off
      check("R7 permit idle", {31'd0, wb_permit}, 32'h1);
      ev_wdh = 1; step(); ev_wdh = 0;
      check("R7 permit low", {31'd0, wb_permit}, 32'h0);
      wr(2'd0, 32'h2);
      check("R7 permit back", {31'd0, wb_permit}, 32'h1);

      // R4 frame-number overflow
      frame_msb = 1; step();
      rd(2'd0, v); check("R4 no set before copy", v & 32'h20, 32'h0);
      frame_copy_done = 1; step(); frame_copy_done = 0;
      rd(2'd0, v); check("R4 rise flip", v & 32'h20, 32'h20);
      wr(2'd0, 32'h20);
      frame_copy_done = 1; step(); frame_copy_done = 0;
      rd(2'd0, v); check("R4 no flip no set", v & 32'h20, 32'h0);
      frame_msb = 0; frame_copy_done = 1; step(); frame_copy_done = 0;
      rd(2'd0, v); check("R4 fall flip", v & 32'h20, 32'h20);
      wr(2'd0, 32'h20);

      // R6 resume detection
      sw_resume = 1; resume_line = 1; step();
      rd(2'd0, v); check("R6 software resume ignored", v & 32'h8, 32'h0);
      sw_resume = 0; resume_line = 0; step();
      resume_line = 1; step();
      rd(2'd0, v); check("R6 remote edge", v & 32'h8, 32'h8);
      wr(2'd0, 32'h8);
      step();
      rd(2'd0, v); check("R6 held level no reset", v & 32'h8, 32'h0);
      resume_line = 0;

      // R10 interrupt gating
      wr(2'd1, 32'h0000_0001);
      ev_so = 1; step(); ev_so = 0;
      check("R10 no master", {31'd0, irq}, 32'h0);
      wr(2'd1, 32'h8000_0001);
      check("R10 master on", {31'd0, irq}, 32'h1);
      wr(2'd0, 32'h1);
      check("R10 cleared", {31'd0, irq}, 32'h0);

      // R9 ownership change routed only to smi
      wr(2'd1, 32'hC000_0000);
      ev_oc = 1; step(); ev_oc = 0;
      check("R9 smi", {30'd0, smi, irq}, 32'h2);
      check("R9 nosmi smi", {30'd0, smi_ns, status_ns[30]}, 32'h0);

      summary();
      $finish;
   end
endmodule